// File: doc/BRIEF.md
# Three-Stage Interrupt Priority Arbiter

This block chooses which of a parameterised set of interrupt sources, or a debug service request, may interrupt the processor in the next cycle. Each source presents a pending bit, an enable bit, a 4-bit interrupt level and a 3-bit group level. The result is produced in three steps. First, a tournament tree picks the strongest eligible interrupt using a 7-bit key. Second, that winner's interrupt level is weighed against the 5-bit priority of a debug request. Third, the survivor must beat the processor's current 4-bit level.

Priority fields arrive on flat parallel ports. Source `i` occupies bits `[4*i+3:4*i]` of the level bus and bits `[3*i+2:3*i]` of the group bus. The block has no data stream and so no back-pressure. It re-evaluates every cycle, and the outputs always show the decision for the inputs sampled at the previous rising clock edge. A consumer that cannot take a grant simply leaves the request pending. A second output, `cfg_clash`, reports the configuration error in which two eligible sources share the same key.

Top module: `irq_prio_arbiter`

## Requirements
- R1: Among eligible sources, the one with the largest stage-one key wins stage one. The key is `{level[3:0], group[2:0]}`, with the level as the more significant part.
- R2: With `GROUP_EXT`=0, group bit 2 is treated as 0. Only 64 distinct keys exist, and sources that differ only in that bit compare as equal.
- R3: A source is eligible only when both its pending and enable bits are 1. An ineligible source never wins and never takes part in clash detection.
- R4: In stage two, the interrupt winner's priority is `{1'b0, level}` and its group is ignored. The debug request wins when its 5-bit priority is greater than or equal to that value. A debug priority with bit 4 set therefore always wins, and an interrupt grant always has `grant_prio[4]`=0.
- R5: A debug request enters at stage two, even when no interrupt is eligible. When it is granted, `grant_dbg`=1, `grant_prio` equals its priority and `grant_idx`=0.
- R6: A grant is issued only when the stage-two priority is strictly greater than `{1'b0, cpu_lvl}`. An interrupt of level 0 and a debug request of priority 0 are never granted.
- R7: `cfg_clash`=1 when two or more eligible sources have the same effective key. The lowest-indexed of the tied sources is then chosen.
- R8: While `grant_vld`=0, the outputs `grant_dbg`, `grant_idx` and `grant_prio` are all 0.
- R9: All outputs are registered with one cycle of latency. A synchronous active-high `rst` clears every output to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_pend | input | NUM_SRC | Pending bit per source |
| req_en | input | NUM_SRC | Enable bit per source |
| irq_lvl | input | 4*NUM_SRC | Interrupt level per source, packed |
| grp_lvl | input | 3*NUM_SRC | Group level per source, packed; bit 2 is the extension bit |
| dbg_req | input | 1 | Debug service request |
| dbg_prio | input | 5 | Debug request priority |
| cpu_lvl | input | 4 | Current processor priority level |
| grant_vld | output | 1 | A request is granted |
| grant_dbg | output | 1 | The granted request is the debug request |
| grant_idx | output | clog2(NUM_SRC) | Index of the granted interrupt source |
| grant_prio | output | 5 | Priority of the granted request |
| cfg_clash | output | 1 | Two eligible sources share a key |

## Verification
Each test compares two small builds, eight sources with the extension bit and four without, against an arithmetic model on every cycle.

- **Single-source sweeps over level and `cpu_lvl`.** These separate strict from non-strict comparison at stage three.
- **Debug-priority sweeps against fixed interrupt levels.** These expose the tie rule, the zero-extension and the dominance of a set priority MSB.
- **Directed patterns.** These cover a pending-but-disabled high source, equal keys, and keys that differ only in the extension bit, which show up as clashes only in the narrow build.
- **Long random phase.** Levels and groups are drawn from narrowed ranges so that ties and clashes come up often.

// File: rtl/irq_arb_pkg.sv
package irq_arb_pkg;
  localparam int LVL_W  = 4;
  localparam int GRP_W  = 3;
  localparam int KEY_W  = LVL_W + GRP_W;
  localparam int PRIO_W = LVL_W + 1;
endpackage

// File: rtl/irq_arb_key_tree.sv
// Stage one: balanced max tree; on equal keys the left (lower index) side wins.
module irq_arb_key_tree
  import irq_arb_pkg::*;
#(
  parameter int N     = 32,
  parameter int IDX_W = $clog2(N)
) (
  input  logic [N-1:0]       elig,
  input  logic [N*KEY_W-1:0] keys,
  output logic               win_vld,
  output logic [IDX_W-1:0]   win_idx,
  output logic [LVL_W-1:0]   win_lvl
);
  localparam int P = 1 << IDX_W;

  logic             nv [1:2*P-1];
  logic [KEY_W-1:0] nk [1:2*P-1];
  logic [IDX_W-1:0] ni [1:2*P-1];

  for (genvar j = 0; j < P; j++) begin : g_leaf
    if (j < N) begin : g_real
      assign nv[P+j] = elig[j];
      assign nk[P+j] = keys[j*KEY_W +: KEY_W];
    end else begin : g_pad
      assign nv[P+j] = 1'b0;
      assign nk[P+j] = '0;
    end
    assign ni[P+j] = IDX_W'(j);
  end

  for (genvar k = 1; k < P; k++) begin : g_node
    logic take_l;
    assign take_l = nv[2*k] && (!nv[2*k+1] || (nk[2*k] >= nk[2*k+1]));
    assign nv[k]  = nv[2*k] | nv[2*k+1];
    assign nk[k]  = take_l ? nk[2*k] : nk[2*k+1];
    assign ni[k]  = take_l ? ni[2*k] : ni[2*k+1];
  end

  assign win_vld = nv[1];
  assign win_idx = ni[1];
  assign win_lvl = nk[1][KEY_W-1 -: LVL_W];
endmodule

// File: rtl/irq_arb_clash.sv
// Pairwise equal-key detector over eligible sources.
module irq_arb_clash
  import irq_arb_pkg::*;
#(
  parameter int N = 32
) (
  input  logic [N-1:0]       elig,
  input  logic [N*KEY_W-1:0] keys,
  output logic               clash
);
  logic [N*N-1:0] hit;

  for (genvar i = 0; i < N; i++) begin : g_row
    for (genvar j = 0; j < N; j++) begin : g_col
      if (j > i) begin : g_pair
        assign hit[i*N+j] = elig[i] && elig[j] &&
                            (keys[i*KEY_W +: KEY_W] == keys[j*KEY_W +: KEY_W]);
      end else begin : g_none
        assign hit[i*N+j] = 1'b0;
      end
    end
  end

  assign clash = |hit;
endmodule

// File: rtl/irq_arb_resolve.sv
// Stages two and three: debug compare, then processor-level compare.
module irq_arb_resolve
  import irq_arb_pkg::*;
(
  input  logic              s1_vld,
  input  logic [LVL_W-1:0]  s1_lvl,
  input  logic              dbg_req,
  input  logic [PRIO_W-1:0] dbg_prio,
  input  logic [LVL_W-1:0]  cpu_lvl,
  output logic              g_vld,
  output logic              g_dbg,
  output logic [PRIO_W-1:0] g_prio
);
  logic [PRIO_W-1:0] irq_ext;
  logic [PRIO_W-1:0] cpu_ext;
  logic              dbg_win;
  logic              s2_vld;

  always_comb begin
    irq_ext = {1'b0, s1_lvl};
    cpu_ext = {1'b0, cpu_lvl};
    // equal priority goes to the debug request
    dbg_win = dbg_req && (!s1_vld || (dbg_prio >= irq_ext));
    s2_vld  = s1_vld || dbg_req;
    g_prio  = dbg_win ? dbg_prio : irq_ext;
    g_vld   = s2_vld && (g_prio > cpu_ext);
    g_dbg   = dbg_win;
  end
endmodule

// File: rtl/irq_prio_arbiter.sv
module irq_prio_arbiter
  import irq_arb_pkg::*;
#(
  parameter int NUM_SRC   = 32,
  parameter bit GROUP_EXT = 1'b1,
  localparam int IDX_W    = $clog2(NUM_SRC)
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic [NUM_SRC-1:0]       req_pend,
  input  logic [NUM_SRC-1:0]       req_en,
  input  logic [NUM_SRC*LVL_W-1:0] irq_lvl,
  input  logic [NUM_SRC*GRP_W-1:0] grp_lvl,
  input  logic                     dbg_req,
  input  logic [PRIO_W-1:0]        dbg_prio,
  input  logic [LVL_W-1:0]         cpu_lvl,
  output logic                     grant_vld,
  output logic                     grant_dbg,
  output logic [IDX_W-1:0]         grant_idx,
  output logic [PRIO_W-1:0]        grant_prio,
  output logic                     cfg_clash
);
  logic [NUM_SRC-1:0]       elig;
  logic [NUM_SRC*KEY_W-1:0] keys;
  logic                     s1_vld;
  logic [IDX_W-1:0]         s1_idx;
  logic [LVL_W-1:0]         s1_lvl;
  logic                     g_vld, g_dbg, clash;
  logic [PRIO_W-1:0]        g_prio;

  assign elig = req_pend & req_en;

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_key
    logic [GRP_W-1:0] grp_eff;
    if (GROUP_EXT) begin : g_ext
      assign grp_eff = grp_lvl[i*GRP_W +: GRP_W];
    end else begin : g_noext
      assign grp_eff = {1'b0, grp_lvl[i*GRP_W +: GRP_W-1]};
    end
    assign keys[i*KEY_W +: KEY_W] = {irq_lvl[i*LVL_W +: LVL_W], grp_eff};
  end

  irq_arb_key_tree #(.N(NUM_SRC), .IDX_W(IDX_W)) u_tree (
    .elig(elig), .keys(keys),
    .win_vld(s1_vld), .win_idx(s1_idx), .win_lvl(s1_lvl)
  );

  irq_arb_clash #(.N(NUM_SRC)) u_clash (
    .elig(elig), .keys(keys), .clash(clash)
  );

  irq_arb_resolve u_resolve (
    .s1_vld(s1_vld), .s1_lvl(s1_lvl), .dbg_req(dbg_req), .dbg_prio(dbg_prio),
    .cpu_lvl(cpu_lvl), .g_vld(g_vld), .g_dbg(g_dbg), .g_prio(g_prio)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      grant_vld  <= 1'b0;
      grant_dbg  <= 1'b0;
      grant_idx  <= '0;
      grant_prio <= '0;
      cfg_clash  <= 1'b0;
    end else begin
      grant_vld  <= g_vld;
      grant_dbg  <= g_vld && g_dbg;
      grant_idx  <= (g_vld && !g_dbg) ? s1_idx : '0;
      grant_prio <= g_vld ? g_prio : '0;
      cfg_clash  <= clash;
    end
  end

  // R3: an interrupt grant names a source that was eligible
  p_src_elig_r3: assert property (@(posedge clk) disable iff (rst)
    (grant_vld && !grant_dbg) |-> ((($past(elig) >> grant_idx) & 1) != 0));

  // R6: the granted priority beats the processor level of that cycle
  p_above_cpu_r6: assert property (@(posedge clk) disable iff (rst)
    grant_vld |-> (grant_prio > {1'b0, $past(cpu_lvl)}));

  // R4: debug priority with its MSB set always takes the grant
  p_dbg_msb_wins_r4: assert property (@(posedge clk) disable iff (rst)
    (dbg_req && dbg_prio[PRIO_W-1]) |=> (grant_vld && grant_dbg));

  // R4: interrupt grants carry a zero-extended level
  p_irq_msb_zero_r4: assert property (@(posedge clk) disable iff (rst)
    (grant_vld && !grant_dbg) |-> !grant_prio[PRIO_W-1]);

  // R8: idle outputs stay zero
  p_idle_zero_r8: assert property (@(posedge clk) disable iff (rst)
    !grant_vld |-> (!grant_dbg && grant_idx == '0 && grant_prio == '0));

  // R7: a clash needs at least two eligible sources
  p_clash_two_r7: assert property (@(posedge clk) disable iff (rst)
    cfg_clash |-> ($countones($past(elig)) >= 2));
endmodule

// File: tb/tb_irq_prio_arbiter.sv
`timescale 1ns/1ps
module tb_irq_prio_arbiter;
  logic clk = 1'b0;
  logic rst = 1'b1;
  always #4 clk = ~clk;

  logic [7:0] s_pend, s_en;
  logic [3:0] s_lvl [8];
  logic [2:0] s_grp [8];
  logic       s_dbg;
  logic [4:0] s_dbgp;
  logic [3:0] s_cpu;
  logic [31:0] lvl_flat;
  logic [23:0] grp_flat;

  always_comb begin
    for (int i = 0; i < 8; i++) begin
      lvl_flat[i*4 +: 4] = s_lvl[i];
      grp_flat[i*3 +: 3] = s_grp[i];
    end
  end

  logic g_vld, g_dbg, g_clash, x_vld, x_dbg, x_clash;
  logic [2:0] g_idx;
  logic [1:0] x_idx;
  logic [4:0] g_prio, x_prio;

  irq_prio_arbiter #(.NUM_SRC(8), .GROUP_EXT(1'b1)) dut (
    .clk(clk), .rst(rst), .req_pend(s_pend), .req_en(s_en),
    .irq_lvl(lvl_flat), .grp_lvl(grp_flat), .dbg_req(s_dbg), .dbg_prio(s_dbgp),
    .cpu_lvl(s_cpu), .grant_vld(g_vld), .grant_dbg(g_dbg), .grant_idx(g_idx),
    .grant_prio(g_prio), .cfg_clash(g_clash));

  irq_prio_arbiter #(.NUM_SRC(4), .GROUP_EXT(1'b0)) dut_nx (
    .clk(clk), .rst(rst), .req_pend(s_pend[3:0]), .req_en(s_en[3:0]),
    .irq_lvl(lvl_flat[15:0]), .grp_lvl(grp_flat[11:0]), .dbg_req(s_dbg),
    .dbg_prio(s_dbgp), .cpu_lvl(s_cpu), .grant_vld(x_vld), .grant_dbg(x_dbg),
    .grant_idx(x_idx), .grant_prio(x_prio), .cfg_clash(x_clash));

  int n_chk = 0;
  int n_bad = 0;
  int cycles = 0;

  function automatic void ref_model(input int n, input bit ext, output bit v,
                                    output bit d, output int idx, output int prio,
                                    output bit cl);
    int kk [8];
    int best = 0;
    int bi = 0;
    bit found = 0;
    int ip;
    bit dwin;
    int p;
    cl = 0;
    for (int i = 0; i < n; i++) begin
      kk[i] = s_lvl[i] * 8 + (ext ? int'(s_grp[i]) : int'(s_grp[i]) % 4);
      if (s_pend[i] && s_en[i] && (!found || kk[i] > best)) begin
        found = 1; best = kk[i]; bi = i;
      end
    end
    for (int i = 0; i < n; i++)
      for (int j = i + 1; j < n; j++)
        if (s_pend[i] && s_en[i] && s_pend[j] && s_en[j] && kk[i] == kk[j]) cl = 1;
    ip   = found ? best / 8 : 0;
    dwin = s_dbg && (!found || int'(s_dbgp) >= ip);
    p    = dwin ? int'(s_dbgp) : ip;
    v    = (found || s_dbg) && (p > int'(s_cpu));
    d    = v && dwin;
    idx  = (v && !dwin) ? bi : 0;
    prio = v ? p : 0;
  endfunction

  task automatic check_all(input string tag);
    bit v, d, cl;
    int idx, prio;
    ref_model(8, 1'b1, v, d, idx, prio, cl);
    n_chk++;
    if (g_vld !== v || g_dbg !== d || int'(g_idx) != idx || int'(g_prio) != prio ||
        g_clash !== cl) begin
      n_bad++;
      $display("FAIL %s dut: vld=%0d dbg=%0d idx=%0d prio=%0d clash=%0d expected %0d %0d %0d %0d %0d",
               tag, g_vld, g_dbg, g_idx, g_prio, g_clash, v, d, idx, prio, cl);
    end
    ref_model(4, 1'b0, v, d, idx, prio, cl);
    n_chk++;
    if (x_vld !== v || x_dbg !== d || int'(x_idx) != idx || int'(x_prio) != prio ||
        x_clash !== cl) begin
      n_bad++;
      $display("FAIL %s dut_nx: vld=%0d dbg=%0d idx=%0d prio=%0d clash=%0d expected %0d %0d %0d %0d %0d",
               tag, x_vld, x_dbg, x_idx, x_prio, x_clash, v, d, idx, prio, cl);
    end
  endtask

  task automatic check_val(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic clear_stim();
    s_pend = '0; s_en = '0; s_dbg = 0; s_dbgp = '0; s_cpu = '0;
    for (int i = 0; i < 8; i++) begin s_lvl[i] = '0; s_grp[i] = '0; end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      n_bad++;
      $display("FAIL watchdog: actual=%0d cycles expected=done", cycles);
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    clear_stim();
    @(negedge clk);
    // R9: reset holds outputs at zero even with a grantable request present
    s_pend = 8'h01; s_en = 8'h01; s_lvl[0] = 4'd9; s_dbg = 1; s_dbgp = 5'd20;
    step(); step();
    check_val("R9 reset vld", int'(g_vld), 0);
    check_val("R9 reset dbg/prio", int'(g_dbg) + int'(g_prio), 0);
    check_val("R9 reset clash", int'(x_vld) + int'(x_prio) + int'(g_clash), 0);
    rst = 0;
    s_dbg = 0;
    step();
    check_all("R9 first cycle");
    check_val("R9 grant idx0 prio", int'(g_prio), 9);
    // R9: one-cycle latency, output unchanged before the edge
    s_cpu = 4'd15;
    #1;
    check_val("R9 latency hold", int'(g_vld), 1);
    step();
    check_val("R9 latency update", int'(g_vld), 0);

    // R6: single source, sweep level against processor level
    clear_stim();
    s_pend = 8'h01; s_en = 8'h01;
    for (int l = 0; l < 16; l++)
      for (int c = 0; c < 16; c++) begin
        s_lvl[0] = 4'(l); s_cpu = 4'(c);
        step();
        check_all("R6 strict level sweep");
      end

    // R4 R5: debug priority sweep against fixed interrupt levels
    for (int li = 0; li < 4; li++)
      for (int c = 0; c < 2; c++)
        for (int dp = 0; dp < 32; dp++) begin
          clear_stim();
          s_dbg = 1; s_dbgp = 5'(dp); s_cpu = (c == 0) ? 4'd0 : 4'd7;
          if (li > 0) begin
            s_pend = 8'h08; s_en = 8'h08;
            s_lvl[3] = (li == 1) ? 4'd0 : (li == 2) ? 4'd5 : 4'd15;
            s_grp[3] = 3'd7;
          end
          step();
          check_all(li == 0 ? "R5 debug alone" : "R4 debug vs irq");
        end

    // R4: tie goes to debug
    clear_stim();
    s_pend = 8'h04; s_en = 8'h04; s_lvl[2] = 4'd6; s_dbg = 1; s_dbgp = 5'd6;
    step();
    check_val("R4 tie debug wins", int'(g_dbg), 1);

    // R3: pending but disabled high source is ignored
    clear_stim();
    s_pend = 8'h24; s_en = 8'h04; s_lvl[2] = 4'd2; s_lvl[5] = 4'd14;
    step();
    check_val("R3 disabled ignored idx", int'(g_idx), 2);
    check_val("R3 disabled prio", int'(g_prio), 2);
    check_all("R3 disabled source");

    // R1: group breaks ties within a level, level dominates group
    clear_stim();
    s_pend = 8'h07; s_en = 8'h07;
    s_lvl[0] = 4'd4; s_grp[0] = 3'd7;
    s_lvl[1] = 4'd5; s_grp[1] = 3'd0;
    s_lvl[2] = 4'd5; s_grp[2] = 3'd1;
    step();
    check_val("R1 key order idx", int'(g_idx), 2);
    check_all("R1 key order");

    // R7: equal keys raise clash, lowest index chosen
    clear_stim();
    s_pend = 8'h42; s_en = 8'h42;
    s_lvl[1] = 4'd8; s_grp[1] = 3'd3; s_lvl[6] = 4'd8; s_grp[6] = 3'd3;
    step();
    check_val("R7 clash flag", int'(g_clash), 1);
    check_val("R7 lowest index", int'(g_idx), 1);

    // R2: keys differing only in extension bit collapse without extension
    clear_stim();
    s_pend = 8'h09; s_en = 8'h09;
    s_lvl[0] = 4'd9; s_grp[0] = 3'd0; s_lvl[3] = 4'd9; s_grp[3] = 3'd4;
    step();
    check_val("R2 ext build idx", int'(g_idx), 3);
    check_val("R2 ext build no clash", int'(g_clash), 0);
    check_val("R2 narrow build idx", int'(x_idx), 0);
    check_val("R2 narrow build clash", int'(x_clash), 1);

    // R8: nothing granted when processor level is high enough
    clear_stim();
    s_pend = 8'hff; s_en = 8'hff; s_cpu = 4'd15;
    for (int i = 0; i < 8; i++) s_lvl[i] = 4'd15;
    step();
    check_val("R8 idle prio", int'(g_prio) + int'(g_idx) + int'(g_dbg), 0);
    check_all("R8 idle with clash");

    // R1 R2 R3 R4 R7: random mix with narrowed fields for frequent ties
    for (int it = 0; it < 6000; it++) begin
      bit narrow;
      narrow = ($urandom % 2) == 0;
      s_pend = 8'($urandom); s_en = 8'($urandom);
      for (int i = 0; i < 8; i++) begin
        s_lvl[i] = narrow ? 4'($urandom % 3) : 4'($urandom);
        s_grp[i] = narrow ? 3'($urandom % 2 * 4 + $urandom % 2) : 3'($urandom);
      end
      s_dbg  = ($urandom % 4) == 0;
      s_dbgp = 5'($urandom);
      s_cpu  = narrow ? 4'($urandom % 2) : 4'($urandom);
      step();
      check_all("R1 random mix");
    end

    // R9: reset in mid-run clears outputs
    s_dbg = 1; s_dbgp = 5'd31;
    rst = 1;
    step();
    check_val("R9 mid reset", int'(g_vld) + int'(g_clash) + int'(x_vld), 0);
    rst = 0;

    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule